// File: doc/BRIEF.md
# Two-Port Memory with Mailbox Interrupts

This block is a two-port memory of 2^ADDR_W words (1024 by 8 by default) in which the two highest addresses double as mailboxes between the ports. A write by one port into the mailbox that belongs to the other port raises an active-low interrupt flag toward that other port. The receiving port clears its flag by accessing its own mailbox with its select and output enable low. Both mailboxes hold ordinary 8-bit messages stored in the array, so the message and the doorbell travel together in one access.

Each port presents an active-low select, an active-low output enable, a read/write line (low means write), an address, write data and an active-low busy input. Busy low inhibits that port's writes and its interrupt side effects. A global interrupt enable turns off all mailbox signalling and leaves the memory working as a plain two-port array. Everything is synchronous to one clock. Read data and interrupt flags are registered.

Top module: `dpm_mailbox`

## Requirements
- R1: In the cycle after a synchronous reset, both interrupt flags read 1 (inactive) and both read data outputs read 0.
- R2: A port writes when select is 0, read/write is 0 and busy is 1. It reads when select is 0, output enable is 0 and read/write is 1. Read data appears at the next clock edge and otherwise holds its last value. A read of an address written in the same cycle returns the old word.
- R3: A left-port write to the highest address (all ones, 0x3FF by default) makes the right flag 0 at the next edge.
- R4: A right-port write to the second-highest address (0x3FE by default) makes the left flag 0 at the next edge.
- R5: The right port clears its flag by asserting select 0 and output enable 0 at the highest address. The left port clears its flag in the same way at the second-highest address. The read/write level does not matter.
- R6: While a port's busy input is 0, that port stores nothing, sets no flag and clears no flag.
- R7: Mailbox words are ordinary storage. A message written to a mailbox reads back unchanged from either port, and a clearing access does not alter it.
- R8: While the interrupt enable is 0, both flags go to 1 at the next edge and no set or clear takes effect. Writes and reads still work. A set attempted while disabled is not remembered once the enable returns to 1.
- R9: When a set and a clear of the same flag happen in the same cycle, the flag is 0 afterwards.
- R10: When both ports write the same address in the same cycle, the left port's data is stored.
- R11: A write by a port to its own mailbox with output enable 1 changes neither flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| irq_en | input | 1 | mailbox interrupt enable, active high |
| l_cs_n | input | 1 | left select, active low |
| l_oe_n | input | 1 | left output enable, active low |
| l_we_n | input | 1 | left read/write, 0 = write |
| l_busy_n | input | 1 | left busy, active low, inhibits writes and mailbox effects |
| l_addr | input | ADDR_W | left address |
| l_wdata | input | DATA_W | left write data |
| l_rdata | output | DATA_W | left read data, registered |
| l_irq_n | output | 1 | interrupt toward the left port, active low |
| r_cs_n | input | 1 | right select, active low |
| r_oe_n | input | 1 | right output enable, active low |
| r_we_n | input | 1 | right read/write, 0 = write |
| r_busy_n | input | 1 | right busy, active low |
| r_addr | input | ADDR_W | right address |
| r_wdata | input | DATA_W | right write data |
| r_rdata | output | DATA_W | right read data, registered |
| r_irq_n | output | 1 | interrupt toward the right port, active low |

## Verification
The storage path is exercised with two full-address sweeps, each in one direction with a different arithmetic data pattern. A wrong address decode, a dropped port or a swapped mailbox shows up as a data mismatch at a specific address. The same sweeps pass through both mailbox addresses, so they also show that a set comes only from a write to the peer's mailbox and a clear only from the owner's own enabled access. Directed patterns then separate the cases that the sweeps cannot: a clear issued while writing, busy gating, the enable override, a set and a clear in the same cycle, and two writes to one address in the same cycle.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic busy_n;
  } port_ctl_t;

  typedef struct packed {
    logic wr;
    logic rd;
    logic set_peer;
    logic clr_own;
  } port_evt_t;

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 10,
  parameter logic [ADDR_W-1:0]    OWN_BOX  = '0,
  parameter logic [ADDR_W-1:0]    PEER_BOX = '0
) (
  input  port_ctl_t          ctl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               irq_en,
  output port_evt_t          evt
);

  logic sel;
  logic rd_access;

  assign sel       = ~ctl.cs_n;
  assign rd_access = sel & ~ctl.oe_n;

  always_comb begin
    evt.wr       = sel & ~ctl.we_n & ctl.busy_n;
    evt.rd       = rd_access & ctl.we_n;
    evt.set_peer = evt.wr & irq_en & (addr == PEER_BOX);
    evt.clr_own  = rd_access & ctl.busy_n & irq_en & (addr == OWN_BOX);
  end

endmodule

// File: rtl/dpm_flag.sv
module dpm_flag (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n_o
);

  always_ff @(posedge clk) begin
    if (rst || !irq_en) begin
      irq_n_o <= 1'b1;
    end else if (set_i) begin
      irq_n_o <= 1'b0;
    end else if (clr_i) begin
      irq_n_o <= 1'b1;
    end
  end

endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NPORT  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORT-1:0]              wr,
  input  logic [NPORT-1:0]              rd,
  input  logic [NPORT-1:0][ADDR_W-1:0]  addr,
  input  logic [NPORT-1:0][DATA_W-1:0]  wdata,
  output logic [NPORT-1:0][DATA_W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Highest port index written first so port 0 (left) lands last and wins.
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wr[p]) begin
        mem[addr[p]] <= wdata[p];
      end
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[p] <= '0;
      end else if (rd[p]) begin
        rdata[p] <= mem[addr[p]];
      end
    end
  end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_en,
  input  logic              l_cs_n,
  input  logic              l_oe_n,
  input  logic              l_we_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_oe_n,
  input  logic              r_we_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam int unsigned       NPORT   = 2;
  localparam logic [ADDR_W-1:0] BOX_R   = '1;
  localparam logic [ADDR_W-1:0] BOX_L   = BOX_R - 1'b1;

  port_ctl_t                        ctl   [NPORT];
  port_evt_t                        evt   [NPORT];
  logic [NPORT-1:0][ADDR_W-1:0]     addr;
  logic [NPORT-1:0][DATA_W-1:0]     wdata;
  logic [NPORT-1:0][DATA_W-1:0]     rdata;
  logic [NPORT-1:0]                 wr;
  logic [NPORT-1:0]                 rd;
  logic [NPORT-1:0]                 irq_n;

  assign ctl[0]   = '{cs_n: l_cs_n, oe_n: l_oe_n, we_n: l_we_n, busy_n: l_busy_n};
  assign ctl[1]   = '{cs_n: r_cs_n, oe_n: r_oe_n, we_n: r_we_n, busy_n: r_busy_n};
  assign addr     = {r_addr, l_addr};
  assign wdata    = {r_wdata, l_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OWN  = (p == 0) ? BOX_L : BOX_R;
    localparam logic [ADDR_W-1:0] PEER = (p == 0) ? BOX_R : BOX_L;

    dpm_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .ctl   (ctl[p]),
      .addr  (addr[p]),
      .irq_en(irq_en),
      .evt   (evt[p])
    );

    assign wr[p] = evt[p].wr;
    assign rd[p] = evt[p].rd;

    dpm_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .irq_en (irq_en),
      .set_i  (evt[NPORT-1-p].set_peer),
      .clr_i  (evt[p].clr_own),
      .irq_n_o(irq_n[p])
    );
  end

  dpm_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NPORT (NPORT)
  ) u_mem (
    .clk  (clk),
    .rst  (rst),
    .wr   (wr),
    .rd   (rd),
    .addr (addr),
    .wdata(wdata),
    .rdata(rdata)
  );

  assign l_rdata = rdata[0];
  assign r_rdata = rdata[1];
  assign l_irq_n = irq_n[0];
  assign r_irq_n = irq_n[1];

endmodule

// File: rtl/dpm_mailbox_chk.sv
module dpm_mailbox_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_en,
  input logic              l_cs_n,
  input logic              l_oe_n,
  input logic              l_we_n,
  input logic              l_busy_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_irq_n,
  input logic              r_cs_n,
  input logic              r_oe_n,
  input logic              r_we_n,
  input logic              r_busy_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] HI = '1;
  localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

  logic l_rings, r_rings, l_ack, r_ack;
  assign l_rings = irq_en && !l_cs_n && !l_we_n && l_busy_n && (l_addr == HI);
  assign r_rings = irq_en && !r_cs_n && !r_we_n && r_busy_n && (r_addr == LO);
  assign l_ack   = irq_en && !l_cs_n && !l_oe_n && l_busy_n && (l_addr == LO);
  assign r_ack   = irq_en && !r_cs_n && !r_oe_n && r_busy_n && (r_addr == HI);

  a_r3_left_rings_right: assert property (@(posedge clk) disable iff (rst)
    l_rings |=> !r_irq_n);

  a_r4_right_rings_left: assert property (@(posedge clk) disable iff (rst)
    r_rings |=> !l_irq_n);

  a_r5_right_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (r_ack && !l_rings) |=> r_irq_n);

  a_r5_left_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (l_ack && !r_rings) |=> l_irq_n);

  a_r6_busy_holds_right_flag: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !l_busy_n && !r_ack) |=> $stable(r_irq_n));

  a_r8_disable_forces_idle: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> (l_irq_n && r_irq_n));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (l_rings && r_ack) |=> !r_irq_n);

endmodule

bind dpm_mailbox dpm_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_en  (irq_en),
  .l_cs_n  (l_cs_n),
  .l_oe_n  (l_oe_n),
  .l_we_n  (l_we_n),
  .l_busy_n(l_busy_n),
  .l_addr  (l_addr),
  .l_irq_n (l_irq_n),
  .r_cs_n  (r_cs_n),
  .r_oe_n  (r_oe_n),
  .r_we_n  (r_we_n),
  .r_busy_n(r_busy_n),
  .r_addr  (r_addr),
  .r_irq_n (r_irq_n)
);

// File: tb/sim_dpm_mailbox.sv
`timescale 1ns/1ps
module sim_dpm_mailbox;

  localparam int AW = 10;
  localparam int DW = 8;
  localparam logic [AW-1:0] HI = '1;
  localparam logic [AW-1:0] LO = HI - 1'b1;

  logic clk = 1'b0;
  logic rst, irq_en;
  logic l_cs_n, l_oe_n, l_we_n, l_busy_n, r_cs_n, r_oe_n, r_we_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dpm_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .irq_en(irq_en),
    .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_busy_n(l_busy_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_busy_n(r_busy_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  function automatic logic [DW-1:0] pat_a(int a);
    return DW'((a * 29 + 7) & 255);
  endfunction
  function automatic logic [DW-1:0] pat_b(int a);
    return DW'(((a * 53 + 3) & 255) ^ 8'h5A);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lport(bit cs, bit oe, bit we, bit busy, int a, int d);
    l_cs_n = cs; l_oe_n = oe; l_we_n = we; l_busy_n = busy;
    l_addr = AW'(a); l_wdata = DW'(d);
  endtask
  task automatic rport(bit cs, bit oe, bit we, bit busy, int a, int d);
    r_cs_n = cs; r_oe_n = oe; r_we_n = we; r_busy_n = busy;
    r_addr = AW'(a); r_wdata = DW'(d);
  endtask
  task automatic idle();
    lport(1, 1, 1, 1, 0, 0);
    rport(1, 1, 1, 1, 0, 0);
  endtask
  task automatic tick();
    @(negedge clk);
  endtask
  task automatic lwrite(int a, int d); lport(0, 1, 0, 1, a, d); tick(); idle(); endtask
  task automatic rwrite(int a, int d); rport(0, 1, 0, 1, a, d); tick(); idle(); endtask
  task automatic lread(int a); lport(0, 0, 1, 1, a, 0); tick(); idle(); endtask
  task automatic rread(int a); rport(0, 0, 1, 1, a, 0); tick(); idle(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    irq_en = 1'b1;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    chk("R1 l_irq_n", l_irq_n, 1);
    chk("R1 r_irq_n", r_irq_n, 1);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);

    // Sweep left writes, R11: own mailbox write sets nothing
    for (int a = 0; a < (1 << AW); a++) begin
      lport(0, 1, 0, 1, a, pat_a(a));
      tick();
      if (a == int'(LO)) chk("R11 own box write l_irq_n", l_irq_n, 1);
      if (a == int'(LO)) chk("R11 own box write r_irq_n", r_irq_n, 1);
    end
    idle();
    tick();
    chk("R3 right flag raised", r_irq_n, 0);
    chk("R3 left flag untouched", l_irq_n, 1);

    // Right reads everything back; R2, R7, R5
    for (int a = 0; a < (1 << AW); a++) begin
      rport(0, 0, 1, 1, a, 0);
      tick();
      chk($sformatf("R2 right read addr %0d", a), r_rdata, pat_a(a));
      if (a == int'(LO)) chk("R5 wrong box no clear", r_irq_n, 0);
    end
    idle();
    chk("R5 right flag cleared", r_irq_n, 1);
    tick();
    chk("R2 rdata holds when idle", r_rdata, pat_a(int'(HI)));

    // Sweep right writes, left reads back
    for (int a = 0; a < (1 << AW); a++) begin
      rport(0, 1, 0, 1, a, pat_b(a));
      tick();
    end
    idle();
    tick();
    chk("R4 left flag raised", l_irq_n, 0);
    chk("R11 right own box write r_irq_n", r_irq_n, 1);
    for (int a = 0; a < (1 << AW); a++) begin
      lport(0, 0, 1, 1, a, 0);
      tick();
      chk($sformatf("R2 left read addr %0d", a), l_rdata, pat_b(a));
    end
    idle();
    chk("R5 left flag cleared", l_irq_n, 1);

    // R7: message survives clearing access, read from both sides
    lwrite(int'(HI), 8'hC3);
    chk("R3 flag after message", r_irq_n, 0);
    rread(int'(HI));
    chk("R7 message to right", r_rdata, 8'hC3);
    chk("R5 cleared by read", r_irq_n, 1);
    lread(int'(HI));
    chk("R7 message unchanged", l_rdata, 8'hC3);

    // R5: clear with read/write low (write while oe low)
    lwrite(int'(HI), 8'h11);
    chk("R3 set again", r_irq_n, 0);
    rport(0, 0, 0, 1, int'(HI), 8'h22);
    tick();
    idle();
    chk("R5 clear while writing", r_irq_n, 1);
    lread(int'(HI));
    chk("R7 written by right", l_rdata, 8'h22);

    // R6: busy on left blocks set and store
    lport(0, 1, 0, 0, int'(HI), 8'h99);
    tick();
    idle();
    chk("R6 busy no set", r_irq_n, 1);
    rread(int'(HI));
    chk("R6 busy no store", r_rdata, 8'h22);
    // R6: busy on right blocks clear
    lwrite(int'(HI), 8'h33);
    rport(0, 0, 1, 0, int'(HI), 0);
    tick();
    idle();
    chk("R6 busy no clear", r_irq_n, 0);
    rread(int'(HI));
    chk("R6 normal clear", r_irq_n, 1);

    // R8: enable override
    lwrite(int'(HI), 8'h44);
    chk("R8 pre set", r_irq_n, 0);
    irq_en = 1'b0;
    tick();
    chk("R8 forced inactive", r_irq_n, 1);
    rwrite(int'(LO), 8'h55);
    chk("R8 no set while off", l_irq_n, 1);
    irq_en = 1'b1;
    tick();
    chk("R8 not remembered", l_irq_n, 1);
    lread(int'(LO));
    chk("R8 store while off", l_rdata, 8'h55);

    // R9: set and clear same cycle; R2 read-first
    lport(0, 1, 0, 1, int'(HI), 8'h66);
    rport(0, 0, 1, 1, int'(HI), 0);
    tick();
    idle();
    chk("R9 set wins", r_irq_n, 0);
    chk("R2 read old word", r_rdata, 8'h44);
    rread(int'(HI));
    chk("R9 then clear", r_irq_n, 1);
    chk("R2 new word", r_rdata, 8'h66);

    // R10: both write same address
    lport(0, 1, 0, 1, 5, 8'hA1);
    rport(0, 1, 0, 1, 5, 8'hB2);
    tick();
    idle();
    rread(5);
    chk("R10 left wins", r_rdata, 8'hA1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule